// File: doc/BRIEF.md
# PWM Channel with Deadband Insertion

This block is one PWM channel. It produces a primary output and a complementary output. A period counter advances on a prescaled tick, which is supplied from outside the block. The counter runs from an active set of period, duty and deadband values. Software writes these values into shadow inputs. The channel copies them into its active registers only when the load strobe is sampled high, and it answers with a one-cycle acknowledge.

When the complementary output is enabled, the deadband value opens a gap at both hand-overs. The primary output turns off and the complementary output waits before it turns on. The complementary output turns off at the period wrap, and the primary output waits before it turns on again.

The channel also keeps three sticky status flags: rise, fall and half-period. Each flag has its own interrupt enable, and the enabled flags are combined into one interrupt line.

Top module: `pwmch_top`

## Requirements
- R1: When `load_req` is sampled high, the shadow period, duty and deadband are copied into the active registers and the counter restarts at 0. `load_ack` is high during the following cycle only. Shadow values that change without a load have no effect on the outputs.
- R2: The counter advances by one on each clock with `tick`, `ch_en` and `start` all 1. It wraps from period-1 to 0 and holds its value otherwise. An active period of 0 keeps the counter at 0.
- R3: While `cnt_rst` is 1, the counter is forced to 0 and held there. Counting resumes when the bit returns to 0.
- R4: Let the effective deadband D be the deadband when `comp_en` is 1, and 0 otherwise. With `pol`=1, the primary output is high for counts c with D <= c < duty.
- R5: With `pol`=1, the complementary output is high for counts c with duty+D <= c < period.
- R6: If the on time (duty-D) or the off time (period-duty-D) is zero or negative, both outputs are driven low, whatever the polarity.
- R7: With `pol`=0, each enabled output is the inverse of its normal waveform.
- R8: `out_en` gates only the primary output, and `comp_en` gates only the complementary output. With `ch_en`=0, both outputs are low.
- R9: `elapsed` bit 2 records a rising edge of the normal primary waveform, bit 1 records a falling edge, and bit 0 records that the counter advanced onto period/2. Each bit is set on the clock after its event and stays set. It is cleared by a 1 in the matching bit of `flag_clr` (a set in the same cycle wins) or by a load.
- R10: `irq` is high whenever a set `elapsed` bit has its enable set: `rise_ie` for bit 2, `fall_ie` for bit 1, `half_ie` for bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled count enable |
| ch_en | input | 1 | Channel enable |
| start | input | 1 | Run/stop |
| out_en | input | 1 | Primary output enable |
| pol | input | 1 | Polarity: 1 normal, 0 inverted |
| cnt_rst | input | 1 | Hold counter at zero |
| comp_en | input | 1 | Complementary output and deadband enable |
| rise_ie | input | 1 | Rise interrupt enable |
| fall_ie | input | 1 | Fall interrupt enable |
| half_ie | input | 1 | Half-period interrupt enable |
| flag_clr | input | 3 | Per-flag clear, same bit order as `elapsed` |
| load_req | input | 1 | Copy shadow values to active registers |
| sh_period | input | W | Shadow period |
| sh_duty | input | W | Shadow duty |
| sh_dead | input | W | Shadow deadband |
| pwm_out | output | 1 | Primary output |
| pwm_comp | output | 1 | Complementary output |
| elapsed | output | 3 | Sticky flags {rise, fall, half} |
| irq | output | 1 | Channel interrupt |
| load_ack | output | 1 | Load done, one cycle |

## Verification
Some assertions depend on assumptions about how the inputs are driven:

- The check that the two outputs are never high together assumes normal polarity, because inverted polarity makes both outputs high during the deadband gap.
- The acknowledge check assumes `load_req` is a level sampled on every clock, so every acknowledge has a request one cycle earlier.
- The counter checks assume that the active period changes only through a load, which also zeroes the counter.

The stimulus drives every input on the falling edge. It raises `load_req` for one cycle at a time, and it alters the shadow values between loads so that the test shows those changes are ignored.

// File: rtl/pwmch_pkg.sv
package pwmch_pkg;

    localparam int FLAG_N    = 3;
    localparam int FLAG_HALF = 0;
    localparam int FLAG_FALL = 1;
    localparam int FLAG_RISE = 2;

    typedef struct packed {
        logic ch_en;
        logic start;
        logic out_en;
        logic pol;
        logic cnt_rst;
        logic comp_en;
    } chan_ctrl_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic half;
    } flag_vec_t;

    // Apply polarity to a raw waveform: 1 keeps it, 0 inverts it.
    function automatic logic apply_pol(input logic raw, input logic pol);
        return pol ? raw : ~raw;
    endfunction

endpackage

// File: rtl/pwmch_counter.sv
module pwmch_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic         load,
    input  logic         adv_en,
    input  logic [W-1:0] per,
    output logic [W-1:0] cnt,
    output logic         half_ev
);
    logic [W-1:0] nxt;
    logic         adv;

    always_comb begin
        adv = adv_en && !hold && !load;
        if (per == '0 || cnt >= per - 1'b1)
            nxt = '0;
        else
            nxt = cnt + 1'b1;
        half_ev = adv && (per != '0) && (nxt == (per >> 1));
    end

    always_ff @(posedge clk) begin
        if (rst || hold || load)
            cnt <= '0;
        else if (adv)
            cnt <= nxt;
    end
endmodule

// File: rtl/pwmch_wave.sv
module pwmch_wave #(
    parameter int W = 16
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] per,
    input  logic [W-1:0] duty,
    input  logic [W-1:0] dead,
    input  logic         comp_en,
    output logic         valid,
    output logic         p_raw,
    output logic         c_raw
);
    localparam int WE = W + 1;

    logic [WE-1:0] d_eff;
    logic [WE-1:0] comp_lo;
    logic [WE-1:0] cnt_x;

    always_comb begin
        d_eff   = comp_en ? {1'b0, dead} : '0;
        comp_lo = {1'b0, duty} + d_eff;
        cnt_x   = {1'b0, cnt};
        valid   = ({1'b0, duty} > d_eff) && (comp_lo < {1'b0, per});
        p_raw   = valid && (cnt_x >= d_eff) && (cnt < duty);
        c_raw   = valid && (cnt_x >= comp_lo) && (cnt < per);
    end
endmodule

// File: rtl/pwmch_flags.sv
module pwmch_flags
    import pwmch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              p_raw,
    input  logic              half_ev,
    input  logic [FLAG_N-1:0] clr,
    input  logic [FLAG_N-1:0] ie,
    output logic [FLAG_N-1:0] flags,
    output logic              irq
);
    logic      p_d;
    flag_vec_t ev;

    always_comb begin
        ev.rise = p_raw && !p_d;
        ev.fall = !p_raw && p_d;
        ev.half = half_ev;
        irq     = |(flags & ie);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_d   <= 1'b0;
            flags <= '0;
        end else begin
            p_d <= p_raw;
            if (load)
                flags <= '0;
            else
                flags <= (flags & ~clr) | ev;
        end
    end
endmodule

// File: rtl/pwmch_top.sv
module pwmch_top
    import pwmch_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         ch_en,
    input  logic         start,
    input  logic         out_en,
    input  logic         pol,
    input  logic         cnt_rst,
    input  logic         comp_en,
    input  logic         rise_ie,
    input  logic         fall_ie,
    input  logic         half_ie,
    input  logic [2:0]   flag_clr,
    input  logic         load_req,
    input  logic [W-1:0] sh_period,
    input  logic [W-1:0] sh_duty,
    input  logic [W-1:0] sh_dead,
    output logic         pwm_out,
    output logic         pwm_comp,
    output logic [2:0]   elapsed,
    output logic         irq,
    output logic         load_ack
);
    chan_ctrl_t   ctl;
    logic [W-1:0] act_per, act_duty, act_dead;
    logic [W-1:0] cnt_q;
    logic         half_ev, valid, p_raw, c_raw;

    assign ctl = '{ch_en: ch_en, start: start, out_en: out_en, pol: pol,
                   cnt_rst: cnt_rst, comp_en: comp_en};

    always_ff @(posedge clk) begin
        if (rst) begin
            act_per  <= '0;
            act_duty <= '0;
            act_dead <= '0;
            load_ack <= 1'b0;
        end else begin
            load_ack <= load_req;
            if (load_req) begin
                act_per  <= sh_period;
                act_duty <= sh_duty;
                act_dead <= sh_dead;
            end
        end
    end

    pwmch_counter #(.W(W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .hold   (ctl.cnt_rst),
        .load   (load_req),
        .adv_en (ctl.ch_en && ctl.start && tick),
        .per    (act_per),
        .cnt    (cnt_q),
        .half_ev(half_ev)
    );

    pwmch_wave #(.W(W)) u_wave (
        .cnt    (cnt_q),
        .per    (act_per),
        .duty   (act_duty),
        .dead   (act_dead),
        .comp_en(ctl.comp_en),
        .valid  (valid),
        .p_raw  (p_raw),
        .c_raw  (c_raw)
    );

    pwmch_flags u_flags (
        .clk    (clk),
        .rst    (rst),
        .load   (load_req),
        .p_raw  (p_raw),
        .half_ev(half_ev),
        .clr    (flag_clr),
        .ie     ({rise_ie, fall_ie, half_ie}),
        .flags  (elapsed),
        .irq    (irq)
    );

    always_comb begin
        pwm_out  = ctl.ch_en && ctl.out_en && valid && apply_pol(p_raw, ctl.pol);
        pwm_comp = ctl.ch_en && ctl.comp_en && valid && apply_pol(c_raw, ctl.pol);
    end
endmodule

// File: rtl/pwmch_checker.sv
module pwmch_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         load_req,
    input logic         load_ack,
    input logic         cnt_rst,
    input logic         ch_en,
    input logic         pol,
    input logic         pwm_out,
    input logic         pwm_comp,
    input logic         irq,
    input logic [2:0]   elapsed,
    input logic [W-1:0] cnt,
    input logic [W-1:0] act_per
);
    assert_ack_follows_req_R1: assert property (@(posedge clk) disable iff (rst)
        load_ack |-> $past(load_req));

    assert_count_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        (act_per != '0) |-> (cnt < act_per));

    assert_halt_freezes_R2: assert property (@(posedge clk) disable iff (rst)
        (!ch_en && !cnt_rst && !load_req) |=> $stable(cnt));

    assert_hold_zero_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_rst |=> (cnt == '0));

    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (rst)
        pol |-> !(pwm_out && pwm_comp));

    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> (elapsed != 3'b000));
endmodule

bind pwmch_top pwmch_checker #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .load_req(load_req),
    .load_ack(load_ack),
    .cnt_rst (cnt_rst),
    .ch_en   (ch_en),
    .pol     (pol),
    .pwm_out (pwm_out),
    .pwm_comp(pwm_comp),
    .irq     (irq),
    .elapsed (elapsed),
    .cnt     (cnt_q),
    .act_per (act_per)
);

// File: tb/pwmch_top_tb.sv
module pwmch_top_tb;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0, ch_en = 1'b0, start = 1'b0, out_en = 1'b0, pol = 1'b1;
    logic cnt_rst = 1'b0, comp_en = 1'b0, rise_ie = 1'b0, fall_ie = 1'b0, half_ie = 1'b0;
    logic [2:0] flag_clr = 3'b000;
    logic load_req = 1'b0;
    logic [W-1:0] sh_period = '0, sh_duty = '0, sh_dead = '0;
    logic pwm_out, pwm_comp, irq, load_ack;
    logic [2:0] elapsed;

    int checks = 0;
    int fails  = 0;
    int tick_div = 1;
    int tick_ph  = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    // reference model state
    int m_cnt = 0, m_per = 0, m_duty = 0, m_dead = 0;
    bit m_pd = 0, m_ack = 0;
    bit [2:0] m_flags = 3'b000;

    always #2 clk = ~clk;

    pwmch_top #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .tick(tick), .ch_en(ch_en), .start(start),
        .out_en(out_en), .pol(pol), .cnt_rst(cnt_rst), .comp_en(comp_en),
        .rise_ie(rise_ie), .fall_ie(fall_ie), .half_ie(half_ie),
        .flag_clr(flag_clr), .load_req(load_req), .sh_period(sh_period),
        .sh_duty(sh_duty), .sh_dead(sh_dead), .pwm_out(pwm_out),
        .pwm_comp(pwm_comp), .elapsed(elapsed), .irq(irq), .load_ack(load_ack)
    );

    function automatic int deff();
        return comp_en ? m_dead : 0;
    endfunction

    function automatic bit m_valid();
        return (m_duty > deff()) && (m_duty + deff() < m_per);
    endfunction

    function automatic bit m_p();
        return m_valid() && m_cnt >= deff() && m_cnt < m_duty;
    endfunction

    function automatic bit m_c();
        return m_valid() && m_cnt >= m_duty + deff() && m_cnt < m_per;
    endfunction

    task automatic cmp(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_per = 0; m_duty = 0; m_dead = 0;
            m_pd = 0; m_ack = 0; m_flags = 3'b000;
        end else begin
            bit p_now, adv, hev;
            int nxt;
            p_now = m_p();
            adv = !cnt_rst && !load_req && ch_en && start && tick;
            nxt = (m_per == 0 || m_cnt >= m_per - 1) ? 0 : m_cnt + 1;
            hev = adv && m_per != 0 && nxt == m_per / 2;
            if (load_req) m_flags = 3'b000;
            else m_flags = (m_flags & ~flag_clr) | {p_now & !m_pd, !p_now & m_pd, hev};
            if (cnt_rst || load_req) m_cnt = 0;
            else if (adv) m_cnt = nxt;
            m_ack = load_req;
            if (load_req) begin
                m_per = int'(sh_period); m_duty = int'(sh_duty); m_dead = int'(sh_dead);
            end
            m_pd = p_now;
        end
        #1;
        if (!done) begin
            bit eo, ec, ei;
            eo = ch_en && out_en && m_valid() && (pol ? m_p() : !m_p());
            ec = ch_en && comp_en && m_valid() && (pol ? m_c() : !m_c());
            ei = |(m_flags & {rise_ie, fall_ie, half_ie});
            cmp("pwm_out (R4)", int'(pwm_out), int'(eo));
            cmp("pwm_comp (R5)", int'(pwm_comp), int'(ec));
            cmp("elapsed (R9)", int'(elapsed), int'(m_flags));
            cmp("irq (R10)", int'(irq), int'(ei));
            cmp("load_ack (R1)", int'(load_ack), int'(m_ack));
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = (tick_ph % tick_div) == 0;
            tick_ph++;
            flag_clr = 3'b000;
            load_req = 1'b0;
        end
    endtask

    task automatic do_load(input int p, input int d, input int db);
        @(negedge clk);
        sh_period = W'(p); sh_duty = W'(d); sh_dead = W'(db);
        load_req = 1'b1;
        tick = (tick_ph % tick_div) == 0;
        tick_ph++;
        step(1);
    endtask

    initial begin
        int wd;
        for (wd = 0; wd < 20000 && !done; wd++) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        step(3);
        rst = 1'b0;
        // basic run, tick every cycle
        cur_req = "R2";
        ch_en = 1; start = 1; out_en = 1; pol = 1;
        do_load(10, 4, 0);
        step(30);
        // slower tick
        tick_div = 3;
        step(40);
        tick_div = 1;
        // complementary with deadband
        cur_req = "R5";
        comp_en = 1;
        do_load(12, 5, 2);
        step(40);
        // shadow change without load ignored
        cur_req = "R1";
        sh_period = 5; sh_duty = 1; sh_dead = 0;
        step(30);
        // invalid on/off times
        cur_req = "R6";
        do_load(10, 2, 2);
        step(25);
        do_load(10, 8, 2);
        step(25);
        comp_en = 0;
        do_load(6, 6, 0);
        step(15);
        pol = 0;
        step(10);
        pol = 1;
        // polarity inverted
        cur_req = "R7";
        comp_en = 1;
        do_load(10, 5, 1);
        pol = 0;
        step(30);
        pol = 1;
        // gating
        cur_req = "R8";
        out_en = 0;
        step(15);
        out_en = 1; comp_en = 0;
        step(15);
        comp_en = 1; ch_en = 0;
        step(15);
        ch_en = 1;
        // counter reset hold
        cur_req = "R3";
        step(3);
        cnt_rst = 1;
        step(10);
        cnt_rst = 0;
        step(20);
        // stop bit holds counter
        cur_req = "R2";
        start = 0;
        step(10);
        start = 1;
        // flags, clears and interrupts
        cur_req = "R9";
        do_load(8, 3, 1);
        step(12);
        @(negedge clk); flag_clr = 3'b111; step(1);
        step(3);
        @(negedge clk); flag_clr = 3'b101; step(1);
        step(10);
        cur_req = "R10";
        rise_ie = 1;
        step(10);
        rise_ie = 0; fall_ie = 1;
        @(negedge clk); flag_clr = 3'b111; step(1);
        step(10);
        fall_ie = 0; half_ie = 1;
        step(10);
        half_ie = 0;
        step(5);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule